// File: doc/BRIEF.md
# Page Write Staging Buffer

This block gathers the data bytes of one serial-memory write transaction into a page-sized staging store. When the transaction ends, it hands those bytes to the storage array as a series of single-byte writes. A transaction opens with a start strobe. The strobe carries a 10-bit address: the upper bits select the page and the low four bits give the first offset inside that 16-byte page. Every byte strobe from the protocol engine lands at the current offset and advances the offset. When the offset passes the last slot of the page it wraps to slot 0, and the page bits never change.

A per-slot valid mask records which slots actually received data. On commit, only the marked slots are written out, one per clock cycle, in ascending offset order. An abort, or a new start that arrives before any commit, discards everything that was staged. While the write-out runs, the block reports busy and does not act on any input strobe.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, `staged_mask_o` is all zero, and both `busy_o` and `wr_vld_o` are low.
- R2: A start strobe while idle loads the page from `start_addr_i[9:4]` and the offset from `start_addr_i[3:0]`, and it clears the staged mask. This holds even when earlier bytes were never committed.
- R3: Each accepted byte strobe stores `byte_i` in the slot at the current offset and sets bit `offset` of `staged_mask_o`. The offset then advances by one, going from 15 to 0 with the page unchanged.
- R4: When more than 16 bytes arrive, a later byte replaces the byte already staged at the same wrapped offset. At most 16 slots are ever marked.
- R5: A commit while the mask is non-empty raises `busy_o` one cycle later. One cycle after that, the first write appears. The block then issues exactly one write per marked slot, one per cycle, in ascending offset order. Each write carries `wr_addr_o = {page, offset}` and the latest byte stored in that slot.
- R6: A transaction with a single byte commits as exactly one write.
- R7: A commit while the mask is empty issues no write and leaves `busy_o` low.
- R8: An abort strobe while idle clears the staged mask. A later commit therefore issues no write.
- R9: While `busy_o` is high, the start, byte, abort and commit strobes are ignored. No slot is marked and the page and offset are kept.
- R10: When a byte strobe and a commit arrive in the same cycle, the byte is staged and included in the write-out.
- R11: In the cycle that the last write appears, `busy_o` is already low and `staged_mask_o` is zero. `wr_vld_o` is low in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a transaction and loads the address |
| start_addr_i | input | 10 | Page (bits 9:4) and first offset (bits 3:0) |
| byte_vld_i | input | 1 | A data byte is present on byte_i |
| byte_i | input | 8 | Data byte |
| commit_i | input | 1 | End of transaction; write the staged bytes |
| abort_i | input | 1 | Discard the staged bytes |
| busy_o | output | 1 | Write-out in progress |
| staged_mask_o | output | 16 | One bit per page slot holding a staged byte |
| wr_vld_o | output | 1 | Array write strobe |
| wr_addr_o | output | 10 | Array write address |
| wr_data_o | output | 8 | Array write data |

## Verification
The staged mask reflects a strobe one cycle after the edge that captures it. After a commit edge, `busy_o` is high in the next cycle, and the k-th write is valid k+1 cycles after that commit edge. The bench drives all strobes just after a falling edge and samples one falling edge later. It walks the expected writes one cycle at a time, in ascending slot order, from a reference model that it keeps itself. For every check, it then confirms that the strobe has dropped in the cycle after the last write.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic {
    ST_FILL  = 1'b0,
    ST_DRAIN = 1'b1
  } pwb_state_e;
endpackage

// File: rtl/pwb_addr_ctr.sv
module pwb_addr_ctr #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned OFF_W  = 4,
  localparam int unsigned PAGE_W = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              step_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [OFF_W-1:0]  off_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_o <= '0;
      off_o  <= '0;
    end else if (load_i) begin
      page_o <= addr_i[ADDR_W-1:OFF_W];
      off_o  <= addr_i[OFF_W-1:0];
    end else if (step_i) begin
      off_o  <= off_o + 1'b1;   // natural wrap inside the page
    end
  end

  p_offset_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && off_o == '1) |=> (off_o == '0 && $stable(page_o)));

  p_page_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(page_o));
endmodule

// File: rtl/pwb_stage.sv
module pwb_stage #(
  parameter int unsigned SLOTS  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned OFF_W = $clog2(SLOTS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clr_i,
  input  logic                          wr_i,
  input  logic [OFF_W-1:0]              wr_off_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  input  logic                          rel_i,
  input  logic [OFF_W-1:0]              rel_off_i,
  output logic [SLOTS-1:0]              mask_o,
  output logic [SLOTS-1:0][DATA_W-1:0]  data_o
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_o[g] <= 1'b0;
        data_o[g] <= '0;
      end else begin
        if (clr_i) begin
          mask_o[g] <= 1'b0;
        end else if (wr_i && wr_off_i == OFF_W'(g)) begin
          mask_o[g] <= 1'b1;
          data_o[g] <= wr_data_i;   // later byte replaces earlier one
        end else if (rel_i && rel_off_i == OFF_W'(g)) begin
          mask_o[g] <= 1'b0;
        end
      end
    end
  end

  p_store_sets_bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i) |=> mask_o[$past(wr_off_i)]);

  p_store_data_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i) |=> data_o[$past(wr_off_i)] == $past(wr_data_i));
endmodule

// File: rtl/pwb_drain.sv
module pwb_drain #(
  parameter int unsigned SLOTS  = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PAGE_W = 6,
  localparam int unsigned OFF_W = $clog2(SLOTS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          en_i,
  input  logic [SLOTS-1:0]              mask_i,
  input  logic [SLOTS-1:0][DATA_W-1:0]  data_i,
  input  logic [PAGE_W-1:0]             page_i,
  output logic [OFF_W-1:0]              pick_off_o,
  output logic                          pick_vld_o,
  output logic                          wr_vld_o,
  output logic [PAGE_W+OFF_W-1:0]       wr_addr_o,
  output logic [DATA_W-1:0]             wr_data_o
);
  // lowest marked slot first
  always_comb begin
    pick_off_o = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (mask_i[i]) pick_off_o = OFF_W'(i);
    end
  end
  assign pick_vld_o = |mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_vld_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_vld_o <= en_i && pick_vld_o;
      if (en_i && pick_vld_o) begin
        wr_addr_o <= {page_i, pick_off_o};
        wr_data_o <= data_i[pick_off_o];
      end
    end
  end

  p_write_needs_drain_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vld_o |-> $past(en_i));

  p_write_page_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vld_o |-> wr_addr_o[PAGE_W+OFF_W-1:OFF_W] == $past(page_i));
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PAGE_BYTES = 16,
  localparam int unsigned OFF_W  = $clog2(PAGE_BYTES),
  localparam int unsigned PAGE_W = ADDR_W - OFF_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [ADDR_W-1:0]     start_addr_i,
  input  logic                  byte_vld_i,
  input  logic [DATA_W-1:0]     byte_i,
  input  logic                  commit_i,
  input  logic                  abort_i,
  output logic                  busy_o,
  output logic [PAGE_BYTES-1:0] staged_mask_o,
  output logic                  wr_vld_o,
  output logic [ADDR_W-1:0]     wr_addr_o,
  output logic [DATA_W-1:0]     wr_data_o
);
  import pwb_pkg::*;

  pwb_state_e                          state_q;
  logic [PAGE_W-1:0]                   page;
  logic [OFF_W-1:0]                    off;
  logic [PAGE_BYTES-1:0]               mask;
  logic [PAGE_BYTES-1:0][DATA_W-1:0]   slot_data;
  logic [OFF_W-1:0]                    pick_off;
  logic                                pick_vld;
  logic                                accept, clr, load, step, commit_go, rel, last_one;

  assign accept    = (state_q == ST_FILL);
  assign clr       = accept && (abort_i || start_i);
  assign load      = accept && start_i && !abort_i;
  assign step      = accept && byte_vld_i && !clr;
  assign commit_go = accept && commit_i && !clr && ((|mask) || step);
  assign rel       = (state_q == ST_DRAIN) && pick_vld;
  assign last_one  = (mask & (mask - PAGE_BYTES'(1))) == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FILL;
    end else begin
      unique case (state_q)
        ST_FILL:  if (commit_go) state_q <= ST_DRAIN;
        ST_DRAIN: if (last_one)  state_q <= ST_FILL;
        default:  state_q <= ST_FILL;
      endcase
    end
  end

  pwb_addr_ctr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .addr_i (start_addr_i),
    .step_i (step),
    .page_o (page),
    .off_o  (off)
  );

  pwb_stage #(.SLOTS(PAGE_BYTES), .DATA_W(DATA_W)) u_stage (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .wr_i      (step),
    .wr_off_i  (off),
    .wr_data_i (byte_i),
    .rel_i     (rel),
    .rel_off_i (pick_off),
    .mask_o    (mask),
    .data_o    (slot_data)
  );

  pwb_drain #(.SLOTS(PAGE_BYTES), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_drain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (state_q == ST_DRAIN),
    .mask_i     (mask),
    .data_i     (slot_data),
    .page_i     (page),
    .pick_off_o (pick_off),
    .pick_vld_o (pick_vld),
    .wr_vld_o   (wr_vld_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o)
  );

  assign busy_o        = (state_q == ST_DRAIN);
  assign staged_mask_o = mask;

  p_abort_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && !busy_o) |=> staged_mask_o == '0);

  p_busy_no_new_bits_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (staged_mask_o & ~$past(staged_mask_o)) == '0);

  p_one_slot_per_cycle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($countones(staged_mask_o) + 1) == $countones($past(staged_mask_o)));

  p_empty_commit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !busy_o && !abort_i && !start_i && !byte_vld_i && staged_mask_o == '0)
      |=> !busy_o);

  p_clean_end_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (staged_mask_o == '0 && wr_vld_o));

  p_byte_with_commit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && commit_i && !busy_o && !abort_i && !start_i) |=> busy_o);
endmodule

// File: tb/page_write_buffer_bench.sv
module page_write_buffer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [9:0]  start_addr_i = '0;
  logic        byte_vld_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        commit_i = 1'b0;
  logic        abort_i = 1'b0;
  logic        busy_o;
  logic [15:0] staged_mask_o;
  logic        wr_vld_o;
  logic [9:0]  wr_addr_o;
  logic [7:0]  wr_data_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [5:0]  m_page = '0;
  logic [3:0]  m_off = '0;
  logic [15:0] m_mask = '0;
  logic [7:0]  m_buf [16];

  always #10 clk_i = ~clk_i;

  page_write_buffer u_page_write_buffer (
    .clk_i, .rst_ni, .start_i, .start_addr_i, .byte_vld_i, .byte_i,
    .commit_i, .abort_i, .busy_o, .staged_mask_o, .wr_vld_o, .wr_addr_o, .wr_data_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic t_start(input logic [9:0] a);
    start_i = 1'b1; start_addr_i = a;
    @(negedge clk_i);
    start_i = 1'b0;
    m_page = a[9:4]; m_off = a[3:0]; m_mask = '0;
    chk(staged_mask_o == 16'h0, "R2", "mask after start", staged_mask_o, 0);
  endtask

  task automatic t_abort();
    abort_i = 1'b1;
    @(negedge clk_i);
    abort_i = 1'b0;
    m_mask = '0;
    chk(staged_mask_o == 16'h0, "R8", "mask after abort", staged_mask_o, 0);
  endtask

  task automatic drain_check(input bit noise, input string req);
    int n;
    bit first;
    n = $countones(m_mask);
    if (n == 0) begin
      chk(busy_o == 1'b0, "R7", "busy on empty commit", busy_o, 0);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk_i);
        chk(wr_vld_o == 1'b0 && busy_o == 1'b0, "R7", "write on empty commit",
            wr_vld_o, 0);
      end
      return;
    end
    chk(busy_o == 1'b1, "R5", "busy after commit", busy_o, 1);
    chk(wr_vld_o == 1'b0, "R5", "early write", wr_vld_o, 0);
    if (noise) begin
      start_i = 1'b1; start_addr_i = 10'h155; byte_vld_i = 1'b1; byte_i = 8'hEE;
      abort_i = 1'b1; commit_i = 1'b1;
    end
    first = 1'b1;
    for (int i = 0; i < 16; i++) begin
      if (m_mask[i]) begin
        @(negedge clk_i);
        if (first) begin
          start_i = 1'b0; byte_vld_i = 1'b0; abort_i = 1'b0; commit_i = 1'b0;
          first = 1'b0;
        end
        chk(wr_vld_o == 1'b1, req, "write strobe", wr_vld_o, 1);
        chk(wr_addr_o == {m_page, 4'(i)}, req, "write addr", wr_addr_o, {m_page, 4'(i)});
        chk(wr_data_o == m_buf[i], req, "write data", wr_data_o, m_buf[i]);
      end
    end
    chk(busy_o == 1'b0, "R11", "busy at last write", busy_o, 0);
    chk(staged_mask_o == 16'h0, noise ? "R9" : "R11", "mask at last write", staged_mask_o, 0);
    @(negedge clk_i);
    chk(wr_vld_o == 1'b0, "R11", "strobe after last write", wr_vld_o, 0);
    m_mask = '0;
  endtask

  task automatic t_byte(input logic [7:0] b, input bit with_commit, input string req);
    byte_vld_i = 1'b1; byte_i = b; commit_i = with_commit;
    @(negedge clk_i);
    byte_vld_i = 1'b0; commit_i = 1'b0;
    m_buf[m_off] = b; m_mask[m_off] = 1'b1; m_off = m_off + 4'd1;
    chk(staged_mask_o == m_mask, req, "staged mask", staged_mask_o, m_mask);
    if (with_commit) drain_check(1'b0, "R10");
  endtask

  task automatic t_commit(input bit noise, input string req);
    commit_i = 1'b1;
    @(negedge clk_i);
    commit_i = 1'b0;
    drain_check(noise, req);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 16; i++) m_buf[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(staged_mask_o == 16'h0 && busy_o == 1'b0 && wr_vld_o == 1'b0, "R1",
        "reset state", {busy_o, wr_vld_o, staged_mask_o}, 0);

    // R2 R3 R5: mid-page start, three bytes
    t_start(10'h0A5);
    t_byte(8'h11, 0, "R3"); t_byte(8'h22, 0, "R3"); t_byte(8'h33, 0, "R3");
    t_commit(0, "R5");

    // R3: wrap from slot 15 to 0 on the last page
    t_start(10'h3FE);
    for (int k = 0; k < 4; k++) t_byte(8'hA0 + 8'(k), 0, "R3");
    t_commit(0, "R3");

    // R4: 20 bytes, slots 0..3 overwritten
    t_start(10'h120);
    for (int k = 0; k < 20; k++) t_byte(8'(k * 7 + 1), 0, "R4");
    chk(staged_mask_o == 16'hFFFF, "R4", "full mask", staged_mask_o, 16'hFFFF);
    t_commit(0, "R4");

    // R6: single byte
    t_start(10'h2C7);
    t_byte(8'h5A, 0, "R6");
    t_commit(0, "R6");

    // R7: empty commit
    t_start(10'h040);
    t_commit(0, "R7");

    // R8: abort then commit
    t_start(10'h081);
    t_byte(8'h01, 0, "R8"); t_byte(8'h02, 0, "R8");
    t_abort();
    t_commit(0, "R8");

    // R2: new start discards uncommitted bytes
    t_start(10'h0F0);
    t_byte(8'h77, 0, "R2");
    t_start(10'h013);
    t_byte(8'h78, 0, "R2");
    t_commit(0, "R2");

    // R10: byte and commit in the same cycle
    t_start(10'h1B9);
    t_byte(8'hC1, 0, "R10");
    t_byte(8'hC2, 1, "R10");

    // R9: strobes during write-out are ignored; offset and page kept
    t_start(10'h36C);
    t_byte(8'h91, 0, "R9"); t_byte(8'h92, 0, "R9");
    t_commit(1, "R9");
    t_byte(8'h93, 0, "R9");
    t_commit(0, "R9");

    // random transactions
    for (int t = 0; t < 30; t++) begin
      int n;
      t_start(10'($urandom_range(0, 1023)));
      n = $urandom_range(1, 20);
      for (int k = 0; k < n; k++) t_byte(8'($urandom), 0, "R3");
      if ($urandom_range(0, 4) == 0) begin
        t_abort();
        t_commit(0, "R8");
      end else begin
        t_commit(1'($urandom_range(0, 1)), "R5");
      end
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule